// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block regulates motor winding current. A comparator outside the block signals when the winding current reaches its limit. If that trip arrives while the chopper is armed, the block clears its source-enable state and holds the high-side source switch off for a fixed number of clock cycles. The current then recirculates through the winding and decays. When the off-time ends, the source switch turns back on. The comparator is then blanked for a short window so that switching spikes cannot cause a false trip.

An external PWM input gates the source switch directly. A rising PWM edge, or a change of the direction input, also opens a blanking window, because each of these causes a switching transient. Whenever the source switch is off, the block raises a synchronous-rectification enable so that the complementary switch conducts during decay. A supply-overvoltage flag suppresses that enable.

Top module: `chop_ctrl`

## Requirements
- R1: After reset, no off-time is pending and no blanking window is open. `src_en_o` equals `pwm_i` from the first cycle, and `sync_rect_o` is high while `pwm_i` is low and `ovp_i` is low.
- R2: A trip is accepted when `trip_i` is sampled high at a clock edge while `pwm_i` is high and no off-time or blanking window is active. After an accepted trip, `src_en_o` stays low for exactly `OFF_CYCLES` clock cycles and then returns high.
- R3: A trip sampled during the off-time is ignored and does not extend the off-time.
- R4: When the off-time ends, a blanking window of `BLANK_CYCLES` cycles opens. A trip sampled at any of the `BLANK_CYCLES` edges that follow the end of the off-time is ignored. The edge after those is the first one at which a trip is accepted.
- R5: A clock edge that samples `pwm_i` rising opens a blanking window. Trips at that edge and at the following `BLANK_CYCLES` edges are ignored.
- R6: A clock edge that samples a change of `dir_i`, in either direction, outside the off-time opens a blanking window with the same timing as R5.
- R7: While `pwm_i` is low, `src_en_o` is low in the same cycle and trips are ignored. A trip seen while PWM is low therefore leaves no off-time pending once PWM returns high. The blanking timer is cleared while `pwm_i` is low.
- R8: `sync_rect_o` is high exactly when `src_en_o` is low and `ovp_i` is low. This covers both PWM-low decay and off-time decay. `ovp_i` high forces `sync_rect_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trip_i | input | 1 | Current-limit comparator trip |
| pwm_i | input | 1 | External PWM, high enables the source switch |
| dir_i | input | 1 | Motor direction; any change opens a blanking window |
| ovp_i | input | 1 | Supply overvoltage flag |
| src_en_o | output | 1 | High-side source switch enable |
| sync_rect_o | output | 1 | Synchronous-rectification enable for decay |

## Verification
The checks made on every cycle cover three rules:
- The output decode: the source switch and rectification are never on together, PWM low always turns the source switch off, and overvoltage always suppresses rectification.
- An off-time only begins after a trip sampled with PWM high.
- An off-time is never followed at once by another off-time.

Only the bench's scenarios can show the exact length of the off-time and the exact edges at which trips are ignored or accepted. To do this, the bench sweeps the delay of a trip after the end of an off-time, after a PWM rise, and after a change of direction in each polarity.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    PH_ARMED = 2'd0,
    PH_OFF   = 2'd1,
    PH_BLANK = 2'd2,
    PH_IDLE  = 2'd3
  } chop_phase_e;

  function automatic int unsigned cnt_width(input int unsigned len);
    return (len < 2) ? 1 : $clog2(len + 1);
  endfunction
endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int unsigned LEN = 8,
  localparam int unsigned W  = chop_pkg::cnt_width(LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_i,
  output logic busy_o,
  output logic last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (load_i)            cnt_q <= W'(LEN);
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/chop_edges.sv
module chop_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic dir_i,
  output logic pwm_rise_o,
  output logic dir_chg_o
);
  logic pwm_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      pwm_q <= pwm_i;
      dir_q <= dir_i;
    end
  end

  assign pwm_rise_o = pwm_i & ~pwm_q;
  assign dir_chg_o  = dir_i ^ dir_q;
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
  parameter int unsigned OFF_CYCLES   = 6250,
  parameter int unsigned BLANK_CYCLES = 375
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic pwm_i,
  input  logic dir_i,
  input  logic ovp_i,
  output logic src_en_o,
  output logic sync_rect_o
);
  import chop_pkg::*;

  logic pwm_rise, dir_chg;
  logic off_busy, off_last, off_load;
  logic blank_busy, blank_last, blank_load, blank_clr;
  chop_phase_e phase;

  chop_edges u_edges (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwm_i      (pwm_i),
    .dir_i      (dir_i),
    .pwm_rise_o (pwm_rise),
    .dir_chg_o  (dir_chg)
  );

  chop_timer #(.LEN(OFF_CYCLES)) u_off_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (1'b0),
    .load_i (off_load),
    .busy_o (off_busy),
    .last_o (off_last)
  );

  chop_timer #(.LEN(BLANK_CYCLES)) u_blank_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (blank_clr),
    .load_i (blank_load),
    .busy_o (blank_busy),
    .last_o (blank_last)
  );

  // Edge events outside the off-time restart blanking; off-time end always does.
  assign blank_load = off_last | (~off_busy & (pwm_rise | dir_chg));
  assign blank_clr  = ~pwm_i;

  always_comb begin
    if (off_busy)        phase = PH_OFF;
    else if (!pwm_i)     phase = PH_IDLE;
    else if (blank_busy) phase = PH_BLANK;
    else                 phase = PH_ARMED;
  end

  // Same-edge blank triggers win over a trip.
  assign off_load    = trip_i & (phase == PH_ARMED) & ~blank_load;
  assign src_en_o    = pwm_i & ~off_busy;
  assign sync_rect_o = ~src_en_o & ~ovp_i;

  if (OFF_CYCLES < 1 || BLANK_CYCLES < 1) begin : g_bad_cfg
    initial $error("chop_ctrl: OFF_CYCLES and BLANK_CYCLES must be at least 1");
  end
endmodule

// File: rtl/chop_ctrl_checker.sv
module chop_ctrl_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic trip_i,
  input logic pwm_i,
  input logic ovp_i,
  input logic src_en_o,
  input logic sync_rect_o,
  input logic off_q
);
  assert_no_overlap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(src_en_o && sync_rect_o));

  assert_decay_rect_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_en_o && !ovp_i) |-> sync_rect_o);

  assert_ovp_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovp_i |-> !sync_rect_o);

  assert_pwm_chop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_i |-> !src_en_o);

  assert_trip_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(off_q) |-> $past(trip_i && pwm_i));

  assert_off_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q |-> !src_en_o);

  assert_blank_after_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(off_q) |=> !off_q);
endmodule

bind chop_ctrl chop_ctrl_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trip_i      (trip_i),
  .pwm_i       (pwm_i),
  .ovp_i       (ovp_i),
  .src_en_o    (src_en_o),
  .sync_rect_o (sync_rect_o),
  .off_q       (off_busy)
);

// File: tb/chop_ctrl_bench.sv
module chop_ctrl_bench;
  localparam int OFF = 8;
  localparam int BLK = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic trip_i = 1'b0, pwm_i = 1'b0, dir_i = 1'b0, ovp_i = 1'b0;
  logic src_en_o, sync_rect_o;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  chop_ctrl #(.OFF_CYCLES(OFF), .BLANK_CYCLES(BLK)) u_chop_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .trip_i(trip_i), .pwm_i(pwm_i),
    .dir_i(dir_i), .ovp_i(ovp_i), .src_en_o(src_en_o), .sync_rect_o(sync_rect_o)
  );

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; cyc(); cyc(); rst_ni = 1'b1;
  endtask

  task automatic pulse_trip();
    trip_i = 1'b1; cyc(); trip_i = 1'b0;
  endtask

  // reset with PWM high, let the reset-time rise/dir blanking expire
  task automatic arm();
    pwm_i = 1'b1; do_reset(); repeat (BLK + 1) cyc();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    pwm_i = 1'b0; do_reset();
    chk("R1 src", src_en_o, 1'b0);
    chk("R1 sync", sync_rect_o, 1'b1);
    pwm_i = 1'b1; #0;
    #1 chk("R1 src follows pwm", src_en_o, 1'b1);

    // R2 exact off-time length
    arm(); pulse_trip();
    for (int i = 0; i < OFF; i++) begin
      chk("R2 off", src_en_o, 1'b0);
      cyc();
    end
    chk("R2 end", src_en_o, 1'b1);

    // R3 trip held through off-time does not extend it
    arm(); pulse_trip(); trip_i = 1'b1;
    repeat (OFF - 1) cyc();
    chk("R3 still off", src_en_o, 1'b0);
    trip_i = 1'b0; cyc();
    chk("R3 end on time", src_en_o, 1'b1);

    // R4 blanking after off-time end, sweep trip delay
    for (int d = 0; d <= BLK + 2; d++) begin
      arm(); pulse_trip(); repeat (OFF) cyc();
      repeat (d) cyc();
      pulse_trip();
      chk($sformatf("R4 d=%0d", d), src_en_o, (d < BLK) ? 1'b1 : 1'b0);
    end

    // R5 blanking after PWM rise
    for (int d = 0; d <= BLK + 2; d++) begin
      pwm_i = 1'b0; do_reset(); cyc();
      pwm_i = 1'b1;
      repeat (d) cyc();
      pulse_trip();
      chk($sformatf("R5 d=%0d", d), src_en_o, (d <= BLK) ? 1'b1 : 1'b0);
    end

    // R6 blanking after DIR change, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      for (int d = 0; d <= BLK + 2; d++) begin
        dir_i = pol[0]; arm();
        dir_i = ~dir_i;
        repeat (d) cyc();
        pulse_trip();
        chk($sformatf("R6 pol=%0d d=%0d", pol, d), src_en_o, (d <= BLK) ? 1'b1 : 1'b0);
      end
    end
    dir_i = 1'b0;

    // R7 PWM low chops at once and masks trips
    arm();
    pwm_i = 1'b0; #1;
    chk("R7 chop", src_en_o, 1'b0);
    trip_i = 1'b1; repeat (3) cyc(); trip_i = 1'b0;
    pwm_i = 1'b1; repeat (BLK + 2) cyc();
    chk("R7 no pending off", src_en_o, 1'b1);

    // R8 rectification decode across pwm/ovp, idle and in off-time
    arm();
    for (int p = 0; p < 2; p++) begin
      for (int o = 0; o < 2; o++) begin
        pwm_i = p[0]; ovp_i = o[0]; #1;
        chk($sformatf("R8 src p=%0d o=%0d", p, o), src_en_o, p[0]);
        chk($sformatf("R8 sync p=%0d o=%0d", p, o), sync_rect_o, ~p[0] & ~o[0]);
      end
    end
    ovp_i = 1'b0; arm(); pulse_trip();
    chk("R8 off decay sync", sync_rect_o, 1'b1);
    ovp_i = 1'b1; #1;
    chk("R8 off decay ovp", sync_rect_o, 1'b0);
    ovp_i = 1'b0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule